// File: doc/BRIEF.md
# Four-Mode Serial Port Engine

This block moves one byte at a time over a serial link in one of four framings. All of them share a single 8-bit shift register and a single reload-driven rate generator. Mode 0 is a clocked synchronous transfer driven by the block as clock master. It can be wired with separate data-in and data-out lines, or with one shared data line whose direction is chosen per transfer. Mode 1 is half-duplex asynchronous: a start bit, eight data bits and a stop bit, with the direction set per transfer. Mode 2 is a bus transmit framing in which the block first signals a start condition (data low while the clock is high) and then clocks eight bits. Mode 3 is a bus receive framing. The clock comes from outside, and the block waits for a start condition, takes in eight bits on rising clock edges and then looks for a stop condition (data rising while the clock is high).

Software-side logic loads the byte, the mode, the reload value and the wiring and direction choices, then pulses `start`. When `done` is high, the received byte is on `rx_data`. `frame_err` tells whether the closing stop was missing. Both serial inputs pass through two-flop synchronizers before use.

Top module: `serport_engine`

## Requirements
- R1: After reset, `done`, `frame_err` and `busy` are 0, `sd_oe` and `sck_oe` are 0, and `sck_out` and `sd_out` idle at 1.
- R2: In mode 0 (mode_sel = 0), eight bits are exchanged least significant bit first. `sck_out` idles high and has a period of 2*(N+1) clock cycles for reload N. Output data changes only while `sck_out` is low. Input data is taken at each rising edge of `sck_out`.
- R3: In mode 0, `sd_oe` is 1 throughout a transfer when `three_wire` = 1 or `dir_tx` = 1. It stays 0 when both are 0, and the byte is then received from `sd_in`.
- R4: In mode 1 (mode_sel = 1) with `dir_tx` = 1, the line carries a 0 start bit, the eight data bits least significant first, and a 1 stop bit. Each bit lasts 8*(N+1) cycles.
- R5: In mode 1 with `dir_tx` = 0, a low level on `sd_in` is confirmed half a bit time later. A low pulse shorter than that is ignored and the receiver keeps waiting. Each data bit is taken at its centre, least significant first.
- R6: In mode 1 receive, a 0 found at the centre of the stop bit sets `frame_err`. The received byte is still presented on `rx_data`.
- R7: In mode 2 (mode_sel = 2), `sd_out` is driven low while `sck_out` is high before the first falling clock. Then the eight bits follow as in mode 0, and `sd_oe` = 1 for the whole transfer.
- R8: In mode 3 (mode_sel = 3), `sd_oe` and `sck_oe` stay 0. The block waits for `sd_in` to fall while `sck_in` is high, then shifts in `sd_in` on eight rising edges of `sck_in`, least significant first. A following rise of `sd_in` while `sck_in` is high ends the transfer without error.
- R9: In mode 3, if `sck_in` falls again after the ninth rising edge before any stop is seen, the transfer ends with `frame_err` = 1 and the byte is kept.
- R10: `done` rises after the last bit, or after the stop where one is used. Both `done` and `frame_err` clear on the clock edge that accepts a new `start`. `busy` is 1 from that edge until `done` rises.
- R11: A `start` pulse while `busy` = 1 is ignored. The running transfer keeps its mode, its byte and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Framing: 0 sync, 1 async, 2 bus transmit, 3 bus receive |
| reload | input | 8 | Rate reload value N |
| tx_data | input | 8 | Byte loaded into the shift register at start |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| three_wire | input | 1 | Mode 0: separate data lines when 1 |
| dir_tx | input | 1 | Modes 0 and 1: transmit direction when 1 |
| rx_data | output | 8 | Shift register contents / received byte |
| done | output | 1 | Transfer finished |
| frame_err | output | 1 | Missing stop detected |
| busy | output | 1 | Transfer in progress |
| sd_in | input | 1 | Serial data line input |
| sd_out | output | 1 | Serial data line output value |
| sd_oe | output | 1 | Serial data output enable |
| sck_in | input | 1 | Serial clock line input (mode 3) |
| sck_out | output | 1 | Serial clock output value |
| sck_oe | output | 1 | Serial clock output enable |

## Verification
A rate generator that reloads from a wrong count shows up at once as a clock period or bit time off from 2*(N+1) or 8*(N+1). The bench measures both edge to edge within the first two bits. A shift register or bit counter out of step shows in the transmitted pattern by the second bit, and in `rx_data` once `done` rises. A receive sequencer stuck in a wrong state appears as `done` never rising, or as a framing flag that contradicts the stop level driven. Every such check falls within one frame of the stimulus.

// File: rtl/serport_pkg.sv
package serport_pkg;

  typedef enum logic [1:0] {
    MD_SYNC  = 2'd0,
    MD_ASYNC = 2'd1,
    MD_BUSTX = 2'd2,
    MD_BUSRX = 2'd3
  } sp_mode_e;

  typedef enum logic [1:0] {
    SY_IDLE,
    SY_STRT,
    SY_LOW,
    SY_HIGH
  } sync_st_e;

  typedef enum logic [2:0] {
    AS_IDLE,
    AS_TX,
    AS_HUNT,
    AS_CONF,
    AS_DATA,
    AS_STOP
  } async_st_e;

  typedef enum logic [2:0] {
    BR_IDLE,
    BR_WSTART,
    BR_BITS,
    BR_WCLK,
    BR_WSTOP
  } busrx_st_e;

endpackage

// File: rtl/serport_rategen.sv
module serport_rategen #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [RW-1:0] reload,
  output logic          tick
);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == reload) begin
        tick  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the divider never runs past the programmed reload
  assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= reload));

endmodule

// File: rtl/serport_sync_ctl.sv
module serport_sync_ctl
  import serport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic with_start,
  input  logic tick,
  input  logic sd_s,
  input  logic tx_bit,
  output logic busy,
  output logic sck,
  output logic sd,
  output logic sh_en,
  output logic sh_bit,
  output logic done_p
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  sync_st_e       st_q, st_d;
  logic [CW-1:0]  bit_q, bit_d;
  logic           samp_q, samp_d;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    samp_d = samp_q;
    sh_en  = 1'b0;
    done_p = 1'b0;
    case (st_q)
      SY_IDLE: begin
        if (go) begin
          st_d  = with_start ? SY_STRT : SY_LOW;
          bit_d = '0;
        end
      end
      SY_STRT: begin
        if (tick) st_d = SY_LOW;
      end
      SY_LOW: begin
        if (tick) begin
          samp_d = sd_s;
          st_d   = SY_HIGH;
        end
      end
      SY_HIGH: begin
        if (tick) begin
          sh_en = 1'b1;
          if (bit_q == LAST) begin
            done_p = 1'b1;
            st_d   = SY_IDLE;
          end else begin
            bit_d = bit_q + 1'b1;
            st_d  = SY_LOW;
          end
        end
      end
      default: st_d = SY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SY_IDLE;
      bit_q  <= '0;
      samp_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      samp_q <= samp_d;
    end
  end

  assign busy   = (st_q != SY_IDLE);
  assign sck    = (st_q != SY_LOW);
  assign sh_bit = samp_q;
  assign sd     = (st_q == SY_STRT) ? 1'b0 :
                  (st_q == SY_IDLE) ? 1'b1 : tx_bit;

  // R2: data held steady through the whole high phase of the clock
  assert_data_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SY_HIGH && $past(st_q == SY_HIGH)) |-> $stable(sd));

  // R7: the start condition is always followed by a low clock phase
  assert_start_then_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SY_STRT && tick) |=> (st_q == SY_LOW));

endmodule

// File: rtl/serport_async_ctl.sv
module serport_async_ctl
  import serport_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic dir_tx,
  input  logic tick,
  input  logic sd_s,
  input  logic tx_bit,
  output logic busy,
  output logic sd,
  output logic sh_en,
  output logic sh_bit,
  output logic done_p,
  output logic ferr_p,
  output logic rclr
);

  localparam int SW = $clog2(OVS);
  localparam int IW = $clog2(DW + 2);
  localparam logic [SW-1:0] SUB_END  = SW'(OVS - 1);
  localparam logic [SW-1:0] SUB_HALF = SW'(OVS / 2 - 1);
  localparam logic [IW-1:0] POS_STOP = IW'(DW + 1);
  localparam logic [IW-1:0] POS_LAST = IW'(DW - 1);

  async_st_e      st_q, st_d;
  logic [SW-1:0]  sub_q, sub_d;
  logic [IW-1:0]  idx_q, idx_d;

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    sh_en  = 1'b0;
    sh_bit = 1'b1;
    done_p = 1'b0;
    ferr_p = 1'b0;
    rclr   = 1'b0;
    case (st_q)
      AS_IDLE: begin
        if (go) begin
          st_d  = dir_tx ? AS_TX : AS_HUNT;
          sub_d = '0;
          idx_d = '0;
        end
      end
      AS_TX: begin
        if (tick) begin
          if (sub_q == SUB_END) begin
            sub_d = '0;
            if (idx_q != '0 && idx_q != POS_STOP) sh_en = 1'b1;
            if (idx_q == POS_STOP) begin
              done_p = 1'b1;
              st_d   = AS_IDLE;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      AS_HUNT: begin
        if (!sd_s) begin
          rclr  = 1'b1;
          sub_d = '0;
          st_d  = AS_CONF;
        end
      end
      AS_CONF: begin
        if (tick) begin
          if (sub_q == SUB_HALF) begin
            sub_d = '0;
            idx_d = '0;
            st_d  = sd_s ? AS_HUNT : AS_DATA;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      AS_DATA: begin
        if (tick) begin
          if (sub_q == SUB_END) begin
            sub_d  = '0;
            sh_en  = 1'b1;
            sh_bit = sd_s;
            if (idx_q == POS_LAST) st_d = AS_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      AS_STOP: begin
        if (tick) begin
          if (sub_q == SUB_END) begin
            done_p = 1'b1;
            ferr_p = !sd_s;
            st_d   = AS_IDLE;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      default: st_d = AS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= AS_IDLE;
      sub_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      idx_q <= idx_d;
    end
  end

  assign busy = (st_q != AS_IDLE);
  assign sd   = (st_q != AS_TX)       ? 1'b1 :
                (idx_q == '0)         ? 1'b0 :
                (idx_q == POS_STOP)   ? 1'b1 : tx_bit;

  // R4: frame position never leaves start..stop
  assert_frame_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AS_TX) |-> (idx_q <= POS_STOP));

  // R5: a confirmation is always preceded by a detected low line
  assert_conf_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AS_CONF && $past(st_q) == AS_HUNT) |-> !$past(sd_s));

endmodule

// File: rtl/serport_busrx_ctl.sv
module serport_busrx_ctl
  import serport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic sck_s,
  input  logic sd_s,
  output logic busy,
  output logic sh_en,
  output logic sh_bit,
  output logic done_p,
  output logic ferr_p
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  busrx_st_e      st_q, st_d;
  logic [CW-1:0]  idx_q, idx_d;
  logic           sck_p, sd_p;
  logic           sck_rise, start_seen, stop_seen;

  assign sck_rise   = sck_s && !sck_p;
  assign start_seen = sck_s && sd_p && !sd_s;
  assign stop_seen  = sck_s && !sd_p && sd_s;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    sh_en  = 1'b0;
    sh_bit = sd_s;
    done_p = 1'b0;
    ferr_p = 1'b0;
    case (st_q)
      BR_IDLE: begin
        if (go) st_d = BR_WSTART;
      end
      BR_WSTART: begin
        if (start_seen) begin
          idx_d = '0;
          st_d  = BR_BITS;
        end
      end
      BR_BITS: begin
        if (sck_rise) begin
          sh_en = 1'b1;
          if (idx_q == LAST) st_d = BR_WCLK;
          else               idx_d = idx_q + 1'b1;
        end
      end
      BR_WCLK: begin
        if (sck_rise) st_d = BR_WSTOP;
      end
      BR_WSTOP: begin
        if (stop_seen) begin
          done_p = 1'b1;
          st_d   = BR_IDLE;
        end else if (!sck_s) begin
          done_p = 1'b1;
          ferr_p = 1'b1;
          st_d   = BR_IDLE;
        end
      end
      default: st_d = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BR_IDLE;
      idx_q <= '0;
      sck_p <= 1'b1;
      sd_p  <= 1'b1;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      sck_p <= sck_s;
      sd_p  <= sd_s;
    end
  end

  assign busy = (st_q != BR_IDLE);

  // R8: bits are only shifted on a rising external clock
  assert_shift_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |-> (sck_s && !sck_p));

  // R9: a framing error only ends a transfer waiting for its stop
  assert_ferr_from_wstop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_p |-> (st_q == BR_WSTOP));

endmodule

// File: rtl/serport_engine.sv
module serport_engine
  import serport_pkg::*;
#(
  parameter int DW  = 8,
  parameter int RW  = 8,
  parameter int OVS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic [RW-1:0] reload,
  input  logic [DW-1:0] tx_data,
  input  logic          start,
  input  logic          three_wire,
  input  logic          dir_tx,
  output logic [DW-1:0] rx_data,
  output logic          done,
  output logic          frame_err,
  output logic          busy,
  input  logic          sd_in,
  output logic          sd_out,
  output logic          sd_oe,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe
);

  sp_mode_e      mode_q, mode_d, mode_in;
  logic [RW-1:0] rld_q, rld_d;
  logic          tw_q, tw_d, dir_q, dir_d;
  logic [DW-1:0] sreg_q, sreg_d;
  logic          done_q, done_d, ferr_q, ferr_d;
  logic [1:0]    sd_sync_q, sck_sync_q;
  logic          sd_s, sck_s;
  logic          start_acc, tick;

  logic sy_busy, sy_sck, sy_sd, sy_sh, sy_bit, sy_done;
  logic as_busy, as_sd, as_sh, as_bit, as_done, as_ferr, as_rclr;
  logic br_busy, br_sh, br_bit, br_done, br_ferr;
  logic sh_en, sh_bit;

  assign mode_in   = sp_mode_e'(mode_sel);
  assign busy      = sy_busy | as_busy | br_busy;
  assign start_acc = start && !busy;
  assign sd_s      = sd_sync_q[1];
  assign sck_s     = sck_sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_sync_q  <= 2'b11;
      sck_sync_q <= 2'b11;
    end else begin
      sd_sync_q  <= {sd_sync_q[0], sd_in};
      sck_sync_q <= {sck_sync_q[0], sck_in};
    end
  end

  serport_rategen #(.RW(RW)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .clr    (start_acc | as_rclr),
    .reload (rld_q),
    .tick   (tick)
  );

  serport_sync_ctl #(.DW(DW)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (start_acc && (mode_in == MD_SYNC || mode_in == MD_BUSTX)),
    .with_start (mode_in == MD_BUSTX),
    .tick       (tick),
    .sd_s       (sd_s),
    .tx_bit     (sreg_q[0]),
    .busy       (sy_busy),
    .sck        (sy_sck),
    .sd         (sy_sd),
    .sh_en      (sy_sh),
    .sh_bit     (sy_bit),
    .done_p     (sy_done)
  );

  serport_async_ctl #(.DW(DW), .OVS(OVS)) u_async (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (start_acc && mode_in == MD_ASYNC),
    .dir_tx (dir_tx),
    .tick   (tick),
    .sd_s   (sd_s),
    .tx_bit (sreg_q[0]),
    .busy   (as_busy),
    .sd     (as_sd),
    .sh_en  (as_sh),
    .sh_bit (as_bit),
    .done_p (as_done),
    .ferr_p (as_ferr),
    .rclr   (as_rclr)
  );

  serport_busrx_ctl #(.DW(DW)) u_busrx (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (start_acc && mode_in == MD_BUSRX),
    .sck_s  (sck_s),
    .sd_s   (sd_s),
    .busy   (br_busy),
    .sh_en  (br_sh),
    .sh_bit (br_bit),
    .done_p (br_done),
    .ferr_p (br_ferr)
  );

  always_comb begin
    case (mode_q)
      MD_SYNC, MD_BUSTX: begin sh_en = sy_sh; sh_bit = sy_bit; end
      MD_ASYNC:          begin sh_en = as_sh; sh_bit = as_bit; end
      default:           begin sh_en = br_sh; sh_bit = br_bit; end
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    rld_d  = rld_q;
    tw_d   = tw_q;
    dir_d  = dir_q;
    sreg_d = sreg_q;
    done_d = done_q;
    ferr_d = ferr_q;
    if (start_acc) begin
      mode_d = mode_in;
      rld_d  = reload;
      tw_d   = three_wire;
      dir_d  = dir_tx;
      sreg_d = tx_data;
      done_d = 1'b0;
      ferr_d = 1'b0;
    end else begin
      if (sh_en) sreg_d = {sh_bit, sreg_q[DW-1:1]};
      if (sy_done | as_done | br_done) done_d = 1'b1;
      if (as_ferr | br_ferr)           ferr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_SYNC;
      rld_q  <= '0;
      tw_q   <= 1'b0;
      dir_q  <= 1'b0;
      sreg_q <= '0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rld_q  <= rld_d;
      tw_q   <= tw_d;
      dir_q  <= dir_d;
      sreg_q <= sreg_d;
      done_q <= done_d;
      ferr_q <= ferr_d;
    end
  end

  always_comb begin
    sck_out = 1'b1;
    sck_oe  = 1'b0;
    sd_out  = 1'b1;
    sd_oe   = 1'b0;
    case (mode_q)
      MD_SYNC: begin
        sck_out = sy_sck;
        sck_oe  = sy_busy;
        sd_out  = sy_sd;
        sd_oe   = sy_busy && (tw_q || dir_q);
      end
      MD_BUSTX: begin
        sck_out = sy_sck;
        sck_oe  = sy_busy;
        sd_out  = sy_sd;
        sd_oe   = sy_busy;
      end
      MD_ASYNC: begin
        sd_out = as_sd;
        sd_oe  = as_busy && dir_q;
      end
      default: ;
    endcase
  end

  assign rx_data   = sreg_q;
  assign done      = done_q;
  assign frame_err = ferr_q;

  // R10: at most one sequencer owns the shared shift register
  assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sy_busy, as_busy, br_busy}));

  // R10: accepting a start clears the completion flag
  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !done);

  // R6: a framing error only ever appears together with completion
  assert_ferr_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> done);

  // R11: a start during a transfer leaves the latched mode alone
  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));

endmodule

// File: tb/serport_engine_bench.sv
module serport_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic [7:0] reload;
  logic [7:0] tx_data;
  logic       start, three_wire, dir_tx, sd_in, sck_in;
  logic [7:0] rx_data;
  logic       done, frame_err, busy, sd_out, sd_oe, sck_out, sck_oe;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] g_got;
  int         g_per;
  logic       g_strt, g_oe;

  always #2 clk = ~clk;

  serport_engine u_serport_engine (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .reload(reload),
    .tx_data(tx_data), .start(start), .three_wire(three_wire), .dir_tx(dir_tx),
    .rx_data(rx_data), .done(done), .frame_err(frame_err), .busy(busy),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    report();
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // clock-master transfer; bench acts as slave on sd_in
  task automatic run_sync(input logic [1:0] md, input logic [7:0] n, input logic [7:0] txb,
                          input logic [7:0] slv, input logic tw, input logic dt);
    logic prev;
    int kf, kr, last, cyc;
    mode_sel = md; reload = n; tx_data = txb; three_wire = tw; dir_tx = dt; sd_in = 1'b1;
    g_got = '0; g_per = 0; g_strt = 1'b0; g_oe = 1'b0;
    pulse_start();
    prev = 1'b1; kf = 0; kr = 0; last = -1; cyc = 0;
    while (cyc < 5000) begin
      if (sd_oe) g_oe = 1'b1;
      if (md == 2'd2 && kf == 0 && sck_out && sd_oe && !sd_out) g_strt = 1'b1;
      if (prev && !sck_out) begin
        if (kf < 8) sd_in = slv[kf];
        kf++;
      end
      if (!prev && sck_out) begin
        if (kr < 8) g_got[kr] = sd_out;
        kr++;
        if (last >= 0) g_per = cyc - last;
        last = cyc;
      end
      prev = sck_out;
      if (done) break;
      @(negedge clk);
      cyc++;
    end
    sd_in = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 busy", busy, 0);
    chk("R1 oes", {sd_oe, sck_oe}, 0);
    chk("R1 idle lines", {sck_out, sd_out}, 2'b11);
  endtask

  task automatic t_mode0_3wire();
    run_sync(2'd0, 8'd2, 8'hA5, 8'h3C, 1'b1, 1'b1);
    chk("R2 transmitted byte", g_got, 8'hA5);
    chk("R2 received byte", rx_data, 8'h3C);
    chk("R2 sck period N=2", g_per, 6);
    chk("R3 3-wire oe", g_oe, 1);
    chk("R10 done after last bit", done, 1);
    @(negedge clk) chk("R10 busy low after done", busy, 0);
  endtask

  task automatic t_mode0_2wire_rx();
    run_sync(2'd0, 8'd5, 8'hFF, 8'h96, 1'b0, 1'b0);
    chk("R3 2-wire receive oe", g_oe, 0);
    chk("R3 2-wire received byte", rx_data, 8'h96);
    chk("R2 sck period N=5", g_per, 12);
  endtask

  task automatic t_mode0_fast();
    run_sync(2'd0, 8'd0, 8'h4E, 8'h00, 1'b1, 1'b1);
    chk("R2 sck period N=0", g_per, 2);
    chk("R2 transmitted byte N=0", g_got, 8'h4E);
  endtask

  task automatic t_done_clear();
    chk("R10 done set before restart", done, 1);
    mode_sel = 2'd0; reload = 8'd3; tx_data = 8'h11; three_wire = 1'b1; dir_tx = 1'b1;
    pulse_start();
    chk("R10 done cleared by start", done, 0);
    chk("R10 busy after start", busy, 1);
    while (!done) @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    fork
      run_sync(2'd0, 8'd3, 8'hC3, 8'h5A, 1'b1, 1'b1);
      begin
        repeat (12) @(negedge clk);
        mode_sel = 2'd1; tx_data = 8'h00; start = 1'b1;
        @(negedge clk) start = 1'b0; mode_sel = 2'd0;
      end
    join
    chk("R11 byte unchanged by ignored start", g_got, 8'hC3);
    chk("R11 timing unchanged", g_per, 8);
    chk("R11 received byte", rx_data, 8'h5A);
  endtask

  task automatic t_async_tx();
    int bt, len;
    bt = 8 * (1 + 1);
    mode_sel = 2'd1; reload = 8'd1; tx_data = 8'hA5; dir_tx = 1'b1;
    pulse_start();
    chk("R4 oe while sending", sd_oe, 1);
    len = 0;
    while (!sd_out && len < 1000) begin len++; @(negedge clk); end
    chk("R4 start bit length", len, bt);
    while (!done) @(negedge clk);
    tx_data = 8'h6C;
    pulse_start();
    repeat (bt / 2 - 1) @(negedge clk);
    chk("R4 start bit level", sd_out, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bt) @(negedge clk);
      chk("R4 data bit", sd_out, {31'd0, tx_data[i]});
    end
    repeat (bt) @(negedge clk);
    chk("R4 stop bit level", sd_out, 1);
    repeat (bt) @(negedge clk);
    chk("R10 done after stop", done, 1);
  endtask

  task automatic drive_frame(input int bt, input logic [7:0] b, input logic stopv);
    sd_in = 1'b0; repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sd_in = b[i]; repeat (bt) @(negedge clk);
    end
    sd_in = stopv; repeat (bt) @(negedge clk);
    sd_in = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic t_async_rx();
    int bt;
    bt = 16;
    mode_sel = 2'd1; reload = 8'd1; dir_tx = 1'b0; tx_data = 8'h00; sd_in = 1'b1;
    pulse_start();
    chk("R4 receive oe low", sd_oe, 0);
    sd_in = 1'b0; repeat (2) @(negedge clk); sd_in = 1'b1;
    repeat (3 * bt) @(negedge clk);
    chk("R5 glitch ignored busy", busy, 1);
    chk("R5 glitch ignored done", done, 0);
    drive_frame(bt, 8'h5B, 1'b1);
    chk("R5 received byte", rx_data, 8'h5B);
    chk("R5 done after stop", done, 1);
    chk("R6 good stop no error", frame_err, 0);
    pulse_start();
    repeat (5) @(negedge clk);
    drive_frame(bt, 8'hD2, 1'b0);
    chk("R6 bad stop error", frame_err, 1);
    chk("R6 byte kept", rx_data, 8'hD2);
    chk("R6 done on bad stop", done, 1);
  endtask

  task automatic t_mode2();
    run_sync(2'd2, 8'd2, 8'h93, 8'h00, 1'b0, 1'b0);
    chk("R7 start condition", g_strt, 1);
    chk("R7 transmitted byte", g_got, 8'h93);
    chk("R7 oe during transfer", g_oe, 1);
    chk("R7 done", done, 1);
  endtask

  task automatic bus_frame(input logic [7:0] b, input logic good);
    int h;
    h = 4;
    mode_sel = 2'd3; sck_in = 1'b1; sd_in = 1'b1; tx_data = 8'h00;
    pulse_start();
    repeat (4) @(negedge clk);
    chk("R8 no drive in mode 3", {sd_oe, sck_oe}, 0);
    sd_in = 1'b0; repeat (h) @(negedge clk);
    sck_in = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sd_in = b[i]; repeat (h) @(negedge clk);
      sck_in = 1'b1; repeat (h) @(negedge clk);
      sck_in = 1'b0;
    end
    sd_in = 1'b0; repeat (h) @(negedge clk);
    sck_in = 1'b1; repeat (h) @(negedge clk);
    if (good) sd_in = 1'b1;
    else      sck_in = 1'b0;
    repeat (2 * h) @(negedge clk);
    sck_in = 1'b1; sd_in = 1'b1;
    repeat (h) @(negedge clk);
  endtask

  task automatic t_mode3();
    bus_frame(8'hB4, 1'b1);
    chk("R8 received byte", rx_data, 8'hB4);
    chk("R8 done on stop", done, 1);
    chk("R8 no framing error", frame_err, 0);
    bus_frame(8'h2F, 1'b0);
    chk("R9 missing stop error", frame_err, 1);
    chk("R9 byte kept", rx_data, 8'h2F);
    chk("R9 done", done, 1);
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 2'd0; reload = 8'd0; tx_data = 8'd0; start = 1'b0;
    three_wire = 1'b1; dir_tx = 1'b1; sd_in = 1'b1; sck_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_3wire();
    t_done_clear();
    t_mode0_2wire_rx();
    t_mode0_fast();
    t_busy_ignore();
    t_async_tx();
    t_async_rx();
    t_mode2();
    t_mode3();
    report();
  end

endmodule